// File: doc/BRIEF.md
# Two-Port Memory with Mailbox Interrupts

This block is a 2048-word by 9-bit memory with two independent synchronous ports, left and right. Each port owns one mailbox word at the top of the address range. The left port owns address 0x7FE and the right port owns 0x7FF. When the opposite port writes a port's mailbox, that port's active-low interrupt goes low. The interrupt stays low until the owning port accesses its own mailbox with select and output enable both high.

No control or status registers exist. Interrupts are raised and cleared only as side effects of ordinary memory accesses. The two mailbox words hold 9 bits of user data like any other location, so a system that does not use interrupts can treat them as plain storage.

Access rules:
- A write happens at a clock edge when a port's `sel` and `wr` are both high.
- A read happens when `sel` and `oe` are high and `wr` is low. The read data appears on the port one cycle later.

Top module: `dpmb_mailbox_irq`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge both interrupt outputs are 1 (inactive) and both read-data outputs are 0.
- R2: A right-port write (`r_sel`=1, `r_wr`=1) to address 0x7FE drives `l_irq_n` to 0 after that edge.
- R3: A left-port write (`l_sel`=1, `l_wr`=1) to address 0x7FF drives `r_irq_n` to 0 after that edge.
- R4: A port with `sel`=0 writes nothing and raises no interrupt, whatever the levels of `wr`, `oe`, the address and the data.
- R5: When the left port has `l_sel`=1, `l_oe`=1 and `l_addr`=0x7FE, `l_irq_n` returns to 1 after that edge, whatever the level of `l_wr`. The right port clears `r_irq_n` the same way at 0x7FF. If `sel` is low or `oe` is low, the interrupt does not clear.
- R6: If one interrupt is set and cleared in the same cycle, the set wins and the interrupt stays low.
- R7: A port that writes its own mailbox does not raise its own interrupt.
- R8: With no set and no clear, an interrupt output keeps its level.
- R9: A read returns, one cycle later, the last value written to that address, including the mailbox addresses. A read in the same cycle as a write to the same address by the other port returns the old value.
- R10: When both ports write the same address in one cycle, the left port's data is stored.
- R11: A port's read-data output holds its value in every cycle in which that port does not read.
- R12: The opposite port reading a mailbox does not clear that mailbox's interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left port select |
| l_wr | input | 1 | Left port write enable |
| l_oe | input | 1 | Left port output enable |
| l_addr | input | 11 | Left port address |
| l_wdata | input | 9 | Left port write data |
| l_rdata | output | 9 | Left port read data (registered) |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_sel | input | 1 | Right port select |
| r_wr | input | 1 | Right port write enable |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | 11 | Right port address |
| r_wdata | input | 9 | Right port write data |
| r_rdata | output | 9 | Right port read data (registered) |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Two things can fall in the same cycle. The first is a set and a clear of the same interrupt: the peer writes a mailbox in the same cycle that its owner reads it. The second is a write and a read of the same word from the two ports. The bench provokes both in directed steps, and also lets them arise in a random phase that keeps the traffic on the mailbox addresses and a few ordinary words. A behavioural model applies set-before-clear priority and read-before-write order. The bench compares both interrupts and both read outputs with this model after every clock.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;
    parameter int ADDR_W = 11;
    parameter int DATA_W = 9;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NPORT = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic  sel;
        logic  wr;
        logic  oe;
        addr_t addr;
        data_t wdata;
    } acc_t;

    // Port 0 (left) owns the word just below the top; port 1 (right) owns the top word.
    function automatic addr_t box_of(input int port);
        addr_t top;
        top = '1;
        return (port == 0) ? addr_t'(top - addr_t'(1)) : top;
    endfunction
endpackage

// File: rtl/dpmb_mem.sv
module dpmb_mem
    import dpmb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  acc_t  req_l,
    input  acc_t  req_r,
    output data_t rdata_l,
    output data_t rdata_r
);
    data_t store [DEPTH];

    logic wen_l, wen_r, ren_l, ren_r;
    assign wen_l = req_l.sel && req_l.wr;
    assign wen_r = req_r.sel && req_r.wr;
    assign ren_l = req_l.sel && req_l.oe && !req_l.wr;
    assign ren_r = req_r.sel && req_r.oe && !req_r.wr;

    // Right first, left last: left wins on a same-address collision.
    always_ff @(posedge clk) begin
        if (wen_r) store[req_r.addr] <= req_r.wdata;
        if (wen_l) store[req_l.addr] <= req_l.wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_l <= '0;
            rdata_r <= '0;
        end else begin
            if (ren_l) rdata_l <= store[req_l.addr];
            if (ren_r) rdata_r <= store[req_r.addr];
        end
    end

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!ren_l && !ren_r) |=> ($stable(rdata_l) && $stable(rdata_r)));
endmodule

// File: rtl/dpmb_decode.sv
module dpmb_decode
    import dpmb_pkg::*;
#(
    parameter addr_t OWN_BOX  = '0,
    parameter addr_t PEER_BOX = '1
) (
    input  logic  sel,
    input  logic  wr,
    input  logic  oe,
    input  addr_t addr,
    output logic  peer_box_write,
    output logic  own_box_access
);
    assign peer_box_write = sel && wr && (addr == PEER_BOX);
    assign own_box_access = sel && oe && (addr == OWN_BOX);
endmodule

// File: rtl/dpmb_flag.sv
module dpmb_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    assert_set_priority_R6: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);
    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/dpmb_mailbox_irq.sv
module dpmb_mailbox_irq
    import dpmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel,
    input  logic              l_wr,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_sel,
    input  logic              r_wr,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);
    acc_t req [NPORT];
    logic peer_wr [NPORT];
    logic own_acc [NPORT];
    logic flag    [NPORT];

    assign req[0] = '{sel: l_sel, wr: l_wr, oe: l_oe, addr: l_addr, wdata: l_wdata};
    assign req[1] = '{sel: r_sel, wr: r_wr, oe: r_oe, addr: r_addr, wdata: r_wdata};

    dpmb_mem u_mem (
        .clk     (clk),
        .rst     (rst),
        .req_l   (req[0]),
        .req_r   (req[1]),
        .rdata_l (l_rdata),
        .rdata_r (r_rdata)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpmb_decode #(
            .OWN_BOX  (box_of(p)),
            .PEER_BOX (box_of(NPORT - 1 - p))
        ) u_dec (
            .sel            (req[p].sel),
            .wr             (req[p].wr),
            .oe             (req[p].oe),
            .addr           (req[p].addr),
            .peer_box_write (peer_wr[p]),
            .own_box_access (own_acc[p])
        );

        // Port p's flag is set by the other port writing p's box.
        dpmb_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (peer_wr[NPORT - 1 - p]),
            .clr_i  (own_acc[p]),
            .flag_o (flag[p])
        );
    end

    assign l_irq_n = ~flag[0];
    assign r_irq_n = ~flag[1];

    localparam addr_t BOX_L = box_of(0);
    localparam addr_t BOX_R = box_of(1);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (l_irq_n && r_irq_n && l_rdata == '0 && r_rdata == '0));
    assert_left_raise_R2: assert property (@(posedge clk) disable iff (rst)
        (r_sel && r_wr && r_addr == BOX_L) |=> !l_irq_n);
    assert_right_raise_R3: assert property (@(posedge clk) disable iff (rst)
        (l_sel && l_wr && l_addr == BOX_R) |=> !r_irq_n);
    assert_no_set_unselected_R4: assert property (@(posedge clk) disable iff (rst)
        (!r_sel && l_irq_n) |=> l_irq_n);
    assert_no_self_raise_R7: assert property (@(posedge clk) disable iff (rst)
        (r_irq_n && !(l_sel && l_wr)) |=> r_irq_n);
endmodule

// File: tb/dpmb_mailbox_irq_test.sv
`timescale 1ns/1ps
module dpmb_mailbox_irq_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_sel = 0, l_wr = 0, l_oe = 0, r_sel = 0, r_wr = 0, r_oe = 0;
    logic [10:0] l_addr = '0, r_addr = '0;
    logic [8:0]  l_wdata = '0, r_wdata = '0;
    logic [8:0]  l_rdata, r_rdata;
    logic        l_irq_n, r_irq_n;

    always #2.5 clk = ~clk;

    dpmb_mailbox_irq uut (
        .clk(clk), .rst(rst),
        .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [8:0] m_mem [int];
    logic [8:0] m_lrd = 0, m_rrd = 0;
    bit m_lf = 0, m_rf = 0;

    task automatic cmp(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag);
        logic [8:0] nl, nr;
        bit sl, cl, sr, cr;
        nl = m_lrd; nr = m_rrd;
        if (rst) begin
            nl = 0; nr = 0; m_lf = 0; m_rf = 0;
        end else begin
            if (l_sel && l_oe && !l_wr) nl = m_mem.exists(int'(l_addr)) ? m_mem[int'(l_addr)] : 9'h0;
            if (r_sel && r_oe && !r_wr) nr = m_mem.exists(int'(r_addr)) ? m_mem[int'(r_addr)] : 9'h0;
            sl = r_sel && r_wr && r_addr == 11'h7FE;
            cl = l_sel && l_oe && l_addr == 11'h7FE;
            sr = l_sel && l_wr && l_addr == 11'h7FF;
            cr = r_sel && r_oe && r_addr == 11'h7FF;
            if (sl) m_lf = 1; else if (cl) m_lf = 0;
            if (sr) m_rf = 1; else if (cr) m_rf = 0;
        end
        if (r_sel && r_wr) m_mem[int'(r_addr)] = r_wdata;
        if (l_sel && l_wr) m_mem[int'(l_addr)] = l_wdata;
        m_lrd = nl; m_rrd = nr;
        @(posedge clk);
        #1;
        cmp(tag, "l_irq_n", int'(l_irq_n), int'(!m_lf));
        cmp(tag, "r_irq_n", int'(r_irq_n), int'(!m_rf));
        cmp(tag, "l_rdata", int'(l_rdata), int'(m_lrd));
        cmp(tag, "r_rdata", int'(r_rdata), int'(m_rrd));
    endtask

    task automatic idle();
        l_sel = 0; l_wr = 0; l_oe = 0; r_sel = 0; r_wr = 0; r_oe = 0;
    endtask
    task automatic lset(bit s, bit w, bit o, logic [10:0] a, logic [8:0] d);
        l_sel = s; l_wr = w; l_oe = o; l_addr = a; l_wdata = d;
    endtask
    task automatic rset(bit s, bit w, bit o, logic [10:0] a, logic [8:0] d);
        r_sel = s; r_wr = w; r_oe = o; r_addr = a; r_wdata = d;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [10:0] POOL [6] = '{11'h7FE, 11'h7FF, 11'h000, 11'h001, 11'h005, 11'h7FD};

    initial begin
        idle();
        rst = 1; step("R1"); step("R1");
        rst = 0;
        // R9: plain storage
        lset(1,1,0,11'h010,9'h1A5); step("R9");
        lset(1,0,1,11'h010,0); step("R9");
        idle(); step("R11"); step("R11");
        // R4: unselected write ignored
        lset(1,1,0,11'h020,9'h055); step("R4");
        lset(0,1,1,11'h020,9'h0AA); step("R4");
        lset(0,1,0,11'h7FF,9'h0AA); step("R4");
        lset(1,0,1,11'h020,0); step("R4");
        // R3 then hold, peer read, owner clear
        lset(1,1,0,11'h7FF,9'h123); step("R3");
        idle(); step("R8"); step("R8");
        lset(1,0,1,11'h7FF,0); step("R12");
        idle(); rset(0,0,1,11'h7FF,0); step("R5");
        rset(1,0,0,11'h7FF,0); step("R5");
        rset(1,0,1,11'h7FF,0); step("R5");
        // R2 then clear with wr high (also own write, R7)
        idle(); rset(1,1,0,11'h7FE,9'h0C3); step("R2");
        idle(); rset(1,0,1,11'h7FE,0); step("R12");
        idle(); lset(1,1,1,11'h7FE,9'h07E); step("R5");
        lset(1,0,1,11'h7FE,0); step("R9");
        // R7: right writes own box without oe
        idle(); rset(1,1,0,11'h7FF,9'h0F0); step("R7");
        idle(); step("R7");
        // R6: set and clear same cycle; read sees old value
        rset(1,1,0,11'h7FE,9'h111); step("R2");
        lset(1,0,1,11'h7FE,0); rset(1,1,0,11'h7FE,9'h1EE); step("R6");
        idle(); step("R6");
        lset(1,0,1,11'h7FE,0); step("R9");
        // R10: collision
        idle(); lset(1,1,0,11'h030,9'h0AB); rset(1,1,0,11'h030,9'h154); step("R10");
        idle(); rset(1,0,1,11'h030,0); step("R10");
        idle(); step("R11");
        // preload pool, then random traffic
        foreach (POOL[i]) begin
            idle(); lset(1,1,0,POOL[i],9'(i + 3)); step("R9");
        end
        for (int n = 0; n < 400; n++) begin
            lset(1'($urandom), 1'($urandom), 1'($urandom), POOL[$urandom % 6], 9'($urandom));
            rset(1'($urandom), 1'($urandom), 1'($urandom), POOL[$urandom % 6], 9'($urandom));
            step("R9");
        end
        idle(); rst = 1; step("R1");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule